// File: doc/BRIEF.md
# Audio Stream Buffer-List DMA Engine

This block serves one audio stream. It walks a ring of buffer descriptors that sit in system memory and moves sample bytes between those buffers and a local stream FIFO. Each descriptor is 16 bytes long. It carries a 64-bit buffer address, a 32-bit buffer length and a flag word. The engine fetches a descriptor the first time a request needs one. It then keeps a byte offset into that buffer and serves each transfer request in chunks that never exceed the configured FIFO size.

When a buffer has been fully consumed, or its length is zero, the engine marks the buffer complete. It raises a sticky completion status if the descriptor asks for one, then steps to the next entry. After the last valid entry it returns to entry 0. A list-wide byte position counter follows every byte moved and returns to zero when the ring wraps. Memory accesses are single bytes on a request/acknowledge port. The FIFO side is a byte push port for playback-from-memory and a byte pop port for capture-to-memory.

Typical use: software programs the list base, the last valid index and the FIFO size, then pulses `list_start`. After that, the stream scheduler issues byte-count requests on `xfer_valid`/`xfer_bytes` and waits for `xfer_done`.

Top module: `bufdesc_dma`

## Requirements
- R1: Byte k of the descriptor for entry i is read from `list_base + 16*i + k`. Bytes 0..7 form the buffer address (little-endian), bytes 8..11 the buffer length (little-endian), and bit 0 of byte 12 is the completion-interrupt flag. Data byte j of a buffer is accessed at buffer address + j.
- R2: A request that needs a descriptor while `list_base` is zero issues no memory access. It sets status bit 2 and finishes with zero bytes moved.
- R3: A descriptor fetch sets the buffer offset (`buf_off`) to 0, and `cur_idx` shows the fetched entry index.
- R4: A request of N bytes moves exactly min(N, length − offset) bytes, reported on `xfer_moved` when `xfer_done` pulses. A zero-byte request on an incomplete buffer moves nothing.
- R5: Each chunk starts with a one-cycle `chunk_go` pulse. `chunk_len` is never zero and never exceeds `fifo_size` (a `fifo_size` of 0 is treated as 1).
- R6: A descriptor of length zero is complete as soon as it is fetched, with no data access.
- R7: A completed buffer whose flag bit is set raises status bit 0. A completed buffer without the flag does not.
- R8: After completion the index advances by one. After the entry equal to `last_idx` it returns to 0, and in the same step the list position returns to 0.
- R9: `list_pos` counts every data byte moved since the last wrap or `list_start`.
- R10: A memory access acknowledged with `mem_err` ends the request at once. It sets status bit 1 and moves no further byte.
- R11: With `dir_to_mem` low, each data byte read from memory is pushed on `fifo_push`. With it high, each byte is popped from `fifo_pop_data` and written to memory, and nothing is pushed.
- R12: After reset the engine is ready, with index, offset, position and status all zero and no memory request.
- R13: Status bits are sticky until cleared by the matching `sts_clr` bit. A clear has no effect on the other bits, and a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| list_start | input | 1 | Restart the ring at entry 0 (honoured when idle) |
| list_base | input | 64 | Descriptor list base address |
| last_idx | input | IDX_W | Index of the last valid descriptor |
| fifo_size | input | FIFO_W | Largest chunk in bytes |
| dir_to_mem | input | 1 | 0: memory to FIFO, 1: FIFO to memory |
| xfer_valid | input | 1 | Transfer request strobe (taken when `xfer_ready`) |
| xfer_bytes | input | 32 | Requested byte count |
| xfer_ready | output | 1 | Engine idle and able to take a request |
| xfer_done | output | 1 | One-cycle pulse when a request finishes |
| xfer_moved | output | 32 | Bytes moved by the last request |
| chunk_go | output | 1 | Start of a chunk |
| chunk_len | output | FIFO_W | Length of the chunk being started |
| mem_req | output | 1 | Memory byte access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access acknowledge |
| mem_err | input | 1 | Access failed (valid with `mem_ack`) |
| mem_rdata | input | 8 | Read data (valid with `mem_ack`) |
| fifo_push | output | 1 | Push one byte into the stream FIFO |
| fifo_push_data | output | 8 | Byte pushed |
| fifo_pop | output | 1 | Pop one byte from the stream FIFO |
| fifo_pop_data | input | 8 | Head byte of the stream FIFO |
| cur_idx | output | IDX_W | Current descriptor index |
| buf_off | output | 32 | Offset within the current buffer |
| list_pos | output | POS_W | Byte position within the list |
| sts | output | 3 | Sticky status: bit 0 completion, bit 1 memory error, bit 2 zero base |
| sts_clr | input | 3 | Clear mask for `sts` |

## Verification
Buffer completion and list wraparound can fall in the same cycle. When the last valid entry carries the completion flag, one step raises the completion status, moves the index back to 0 and clears the list position. The stimulus table provokes this with a request that drains the final descriptor. The run is then judged on status bit 0, `cur_idx` and `list_pos` together after `xfer_done`. The same table also reaches a zero-length entry, where fetch, completion and advance follow one another with no data cycle in between.

// File: rtl/bufdesc_dma_pkg.sv
package bufdesc_dma_pkg;

   localparam int DESC_BYTES  = 16;
   localparam int DESC_LAST   = DESC_BYTES - 1;
   localparam int ADDR_BITS   = 64;
   localparam int LEN_BITS    = 32;
   localparam int STS_BITS    = 3;

   localparam int STS_IOC     = 0;
   localparam int STS_MEMERR  = 1;
   localparam int STS_NOBASE  = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_EVAL,
      ST_CHUNK,
      ST_MOVE,
      ST_POST
   } eng_state_e;

endpackage

// File: rtl/bufdesc_desc_cap.sv
module bufdesc_desc_cap
   import bufdesc_dma_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cap_en,
   input  logic [3:0]           cap_sel,
   input  logic [7:0]           cap_byte,
   output logic [ADDR_BITS-1:0] d_addr,
   output logic [LEN_BITS-1:0]  d_len,
   output logic                 d_ioc
);

   localparam int LANES = (ADDR_BITS + LEN_BITS) / 8;
   localparam int FLAG_LANE = LANES;

   logic [ADDR_BITS+LEN_BITS-1:0] raw_q;
   logic                          ioc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
         ioc_q <= 1'b0;
      end else if (cap_en) begin
         for (int i = 0; i < LANES; i++) begin
            if (cap_sel == 4'(i)) raw_q[8*i +: 8] <= cap_byte;
         end
         if (cap_sel == 4'(FLAG_LANE)) ioc_q <= cap_byte[0];
      end
   end

   assign d_addr = raw_q[ADDR_BITS-1:0];
   assign d_len  = raw_q[ADDR_BITS +: LEN_BITS];
   assign d_ioc  = ioc_q;

endmodule

// File: rtl/bufdesc_span.sv
module bufdesc_span
   import bufdesc_dma_pkg::*;
#(
   parameter int FIFO_W = 16
) (
   input  logic [LEN_BITS-1:0] d_len,
   input  logic [LEN_BITS-1:0] off,
   input  logic [LEN_BITS-1:0] want,
   input  logic [FIFO_W-1:0]   fifo_size,
   output logic                buf_done,
   output logic [LEN_BITS-1:0] take,
   output logic [FIFO_W-1:0]   chunk
);

   logic [LEN_BITS-1:0] rem;
   logic [LEN_BITS-1:0] fsz;

   always_comb begin
      buf_done = (d_len == '0) || (off >= d_len);
      rem      = buf_done ? '0 : (d_len - off);
      take     = (want < rem) ? want : rem;
      fsz      = (fifo_size == '0) ? LEN_BITS'(1) : LEN_BITS'(fifo_size);
      chunk    = (want < fsz) ? want[FIFO_W-1:0] : fsz[FIFO_W-1:0];
   end

endmodule

// File: rtl/bufdesc_ring.sv
module bufdesc_ring #(
   parameter int IDX_W          = 8,
   parameter int POS_W          = 32,
   parameter bit POS_WRAP_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             step,
   input  logic             advance,
   input  logic [IDX_W-1:0] last_idx,
   output logic [IDX_W-1:0] idx,
   output logic [POS_W-1:0] pos
);

   logic wrap_now;
   assign wrap_now = advance && (idx == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           idx <= '0;
      else if (restart)     idx <= '0;
      else if (wrap_now)    idx <= '0;
      else if (advance)     idx <= idx + IDX_W'(1);
   end

   if (POS_WRAP_RESET) begin : g_pos_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  pos <= '0;
         else if (restart || wrap_now) pos <= '0;
         else if (step)               pos <= pos + POS_W'(1);
      end
   end else begin : g_pos_free
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pos <= '0;
         else if (restart) pos <= '0;
         else if (step)    pos <= pos + POS_W'(1);
      end
   end

endmodule

// File: rtl/bufdesc_dma.sv
module bufdesc_dma
   import bufdesc_dma_pkg::*;
#(
   parameter int IDX_W          = 8,
   parameter int FIFO_W         = 16,
   parameter int POS_W          = 32,
   parameter bit POS_WRAP_RESET = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 list_start,
   input  logic [ADDR_BITS-1:0] list_base,
   input  logic [IDX_W-1:0]     last_idx,
   input  logic [FIFO_W-1:0]    fifo_size,
   input  logic                 dir_to_mem,
   input  logic                 xfer_valid,
   input  logic [LEN_BITS-1:0]  xfer_bytes,
   output logic                 xfer_ready,
   output logic                 xfer_done,
   output logic [LEN_BITS-1:0]  xfer_moved,
   output logic                 chunk_go,
   output logic [FIFO_W-1:0]    chunk_len,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [ADDR_BITS-1:0] mem_addr,
   output logic [7:0]           mem_wdata,
   input  logic                 mem_ack,
   input  logic                 mem_err,
   input  logic [7:0]           mem_rdata,
   output logic                 fifo_push,
   output logic [7:0]           fifo_push_data,
   output logic                 fifo_pop,
   input  logic [7:0]           fifo_pop_data,
   output logic [IDX_W-1:0]     cur_idx,
   output logic [LEN_BITS-1:0]  buf_off,
   output logic [POS_W-1:0]     list_pos,
   output logic [STS_BITS-1:0]  sts,
   input  logic [STS_BITS-1:0]  sts_clr
);

   localparam int FCNT_W = $clog2(DESC_BYTES);

   if (IDX_W < 1 || IDX_W > ADDR_BITS - FCNT_W) begin : g_bad_idx
      $error("bufdesc_dma: IDX_W out of range");
   end
   if (FIFO_W < 1 || FIFO_W > LEN_BITS) begin : g_bad_fifo
      $error("bufdesc_dma: FIFO_W out of range");
   end
   if (POS_W < 1) begin : g_bad_pos
      $error("bufdesc_dma: POS_W must be positive");
   end

   eng_state_e           st;
   logic [LEN_BITS-1:0]  xfer_left;
   logic [LEN_BITS-1:0]  moved_q;
   logic [LEN_BITS-1:0]  off_q;
   logic [FCNT_W-1:0]    fcnt;
   logic [FIFO_W-1:0]    chunk_left;
   logic                 loaded;
   logic                 done_q;
   logic [STS_BITS-1:0]  sts_q;
   logic [STS_BITS-1:0]  sts_set;

   logic [ADDR_BITS-1:0] d_addr;
   logic [LEN_BITS-1:0]  d_len;
   logic                 d_ioc;
   logic                 buf_done;
   logic [LEN_BITS-1:0]  take;
   logic [FIFO_W-1:0]    chunk;
   logic [IDX_W-1:0]     idx;
   logic [POS_W-1:0]     pos;

   logic acc_ok, acc_bad, in_fetch, in_move, in_idle, accept, base_zero;

   assign in_fetch  = (st == ST_FETCH);
   assign in_move   = (st == ST_MOVE);
   assign in_idle   = (st == ST_IDLE);
   assign acc_ok    = mem_ack && !mem_err;
   assign acc_bad   = mem_ack && mem_err;
   assign accept    = in_idle && !list_start && xfer_valid;
   assign base_zero = (list_base == '0);

   bufdesc_desc_cap u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (in_fetch && acc_ok),
      .cap_sel  (fcnt),
      .cap_byte (mem_rdata),
      .d_addr   (d_addr),
      .d_len    (d_len),
      .d_ioc    (d_ioc)
   );

   bufdesc_span #(.FIFO_W(FIFO_W)) u_span (
      .d_len     (d_len),
      .off       (off_q),
      .want      (xfer_left),
      .fifo_size (fifo_size),
      .buf_done  (buf_done),
      .take      (take),
      .chunk     (chunk)
   );

   bufdesc_ring #(
      .IDX_W          (IDX_W),
      .POS_W          (POS_W),
      .POS_WRAP_RESET (POS_WRAP_RESET)
   ) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (in_idle && list_start),
      .step     (in_move && acc_ok),
      .advance  ((st == ST_POST) && buf_done),
      .last_idx (last_idx),
      .idx      (idx),
      .pos      (pos)
   );

   // memory port: descriptor bytes while fetching, buffer bytes while moving
   always_comb begin
      mem_req   = in_fetch || in_move;
      mem_we    = in_move && dir_to_mem;
      mem_wdata = fifo_pop_data;
      if (in_fetch)
         mem_addr = list_base + (ADDR_BITS'(idx) << FCNT_W) + ADDR_BITS'(fcnt);
      else
         mem_addr = d_addr + ADDR_BITS'(off_q);
   end

   assign fifo_push      = in_move && acc_ok && !dir_to_mem;
   assign fifo_push_data = mem_rdata;
   assign fifo_pop       = in_move && acc_ok && dir_to_mem;

   assign chunk_go   = (st == ST_CHUNK);
   assign chunk_len  = chunk;
   assign xfer_ready = in_idle;
   assign xfer_done  = done_q;
   assign xfer_moved = moved_q;
   assign cur_idx    = idx;
   assign buf_off    = off_q;
   assign list_pos   = pos;
   assign sts        = sts_q;

   always_comb begin
      sts_set             = '0;
      sts_set[STS_IOC]    = (st == ST_POST) && buf_done && d_ioc;
      sts_set[STS_MEMERR] = (in_fetch || in_move) && acc_bad;
      sts_set[STS_NOBASE] = accept && !loaded && base_zero;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~sts_clr) | sts_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         xfer_left  <= '0;
         moved_q    <= '0;
         off_q      <= '0;
         fcnt       <= '0;
         chunk_left <= '0;
         loaded     <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (list_start) begin
                  loaded <= 1'b0;
                  off_q  <= '0;
               end else if (xfer_valid) begin
                  moved_q   <= '0;
                  xfer_left <= xfer_bytes;
                  if (loaded) begin
                     st <= ST_EVAL;
                  end else if (base_zero) begin
                     done_q <= 1'b1;
                  end else begin
                     fcnt <= '0;
                     st   <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: begin
               if (acc_bad) begin
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end else if (acc_ok) begin
                  if (fcnt == FCNT_W'(DESC_LAST)) begin
                     loaded <= 1'b1;
                     off_q  <= '0;
                     st     <= ST_EVAL;
                  end else begin
                     fcnt <= fcnt + FCNT_W'(1);
                  end
               end
            end
            ST_EVAL: begin
               if (buf_done) begin
                  st <= ST_POST;
               end else if (take == '0) begin
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end else begin
                  xfer_left <= take;
                  st        <= ST_CHUNK;
               end
            end
            ST_CHUNK: begin
               chunk_left <= chunk;
               st         <= ST_MOVE;
            end
            ST_MOVE: begin
               if (acc_bad) begin
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end else if (acc_ok) begin
                  off_q      <= off_q + LEN_BITS'(1);
                  moved_q    <= moved_q + LEN_BITS'(1);
                  xfer_left  <= xfer_left - LEN_BITS'(1);
                  chunk_left <= chunk_left - FIFO_W'(1);
                  if (xfer_left == LEN_BITS'(1))
                     st <= ST_POST;
                  else if (chunk_left == FIFO_W'(1))
                     st <= ST_CHUNK;
               end
            end
            ST_POST: begin
               if (buf_done) loaded <= 1'b0;
               done_q <= 1'b1;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bufdesc_dma_chk.sv
module bufdesc_dma_chk #(
   parameter int IDX_W          = 8,
   parameter int FIFO_W         = 16,
   parameter int POS_W          = 32,
   parameter bit POS_WRAP_RESET = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              list_start,
   input logic [63:0]       list_base,
   input logic [FIFO_W-1:0] fifo_size,
   input logic              xfer_ready,
   input logic              xfer_done,
   input logic              chunk_go,
   input logic [FIFO_W-1:0] chunk_len,
   input logic              mem_req,
   input logic              mem_we,
   input logic [63:0]       mem_addr,
   input logic              mem_ack,
   input logic              mem_err,
   input logic              fifo_push,
   input logic              fifo_pop,
   input logic [IDX_W-1:0]  cur_idx,
   input logic [POS_W-1:0]  list_pos
);

   // R5: chunk length bounded by the FIFO size and never empty
   p_chunk_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_go |-> (chunk_len != '0) && ((fifo_size == '0) || (chunk_len <= fifo_size)));

   // R1: an access is held with a stable address until acknowledged
   p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R10: an errored access ends the request
   p_err_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_err) |=> (!mem_req && xfer_done));

   // R8: index only steps by one or returns to zero
   p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_idx != $past(cur_idx)) |-> ((cur_idx == $past(cur_idx) + IDX_W'(1)) || (cur_idx == '0)));

   // R8: position is zero right after the ring returns to entry 0
   p_wrap_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (POS_WRAP_RESET && (cur_idx == '0) && ($past(cur_idx) != '0)) |-> (list_pos == '0));

   // R2: an idle engine facing a zero base starts no fetch in the next cycle
   p_nobase_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ready && (list_base == '0) && !list_start) |=> !mem_req);

   // R11: the two FIFO directions never act together
   p_one_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_push && fifo_pop));

   // R4: completion is reported only from the idle state
   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> xfer_ready);

endmodule

bind bufdesc_dma bufdesc_dma_chk #(
   .IDX_W          (IDX_W),
   .FIFO_W         (FIFO_W),
   .POS_W          (POS_W),
   .POS_WRAP_RESET (POS_WRAP_RESET)
) u_chk (.*);

// File: tb/bufdesc_dma_tb.sv
`timescale 1ns/1ps
module bufdesc_dma_tb;

   localparam int IDX_W  = 8;
   localparam int FIFO_W = 16;
   localparam int POS_W  = 32;
   localparam logic [63:0] LBASE = 64'h1000;
   localparam logic [63:0] DBASE = 64'h20000;

   typedef struct packed {
      logic [31:0] req;
      logic [31:0] moved;
      logic [31:0] ioc;
      logic [31:0] idx;
      logic [31:0] pos;
      logic [31:0] off;
      logic [31:0] chunks;
      logic [31:0] soff;
      logic [31:0] dent;
   } vec_t;

   // req, moved, ioc, idx, pos, off, chunks, start offset, entry
   localparam vec_t VECS [8] = '{
      '{32'd4,  32'd4, 32'd0, 32'd0, 32'd4,  32'd4,  32'd1, 32'd0, 32'd0},
      '{32'd20, 32'd6, 32'd1, 32'd1, 32'd10, 32'd10, 32'd2, 32'd4, 32'd0},
      '{32'd8,  32'd0, 32'd1, 32'd2, 32'd10, 32'd0,  32'd0, 32'd0, 32'd1},
      '{32'd3,  32'd3, 32'd0, 32'd2, 32'd13, 32'd3,  32'd1, 32'd0, 32'd2},
      '{32'd3,  32'd3, 32'd0, 32'd3, 32'd16, 32'd6,  32'd1, 32'd3, 32'd2},
      '{32'd9,  32'd5, 32'd1, 32'd0, 32'd0,  32'd5,  32'd2, 32'd0, 32'd3},
      '{32'd2,  32'd2, 32'd0, 32'd0, 32'd2,  32'd2,  32'd1, 32'd0, 32'd0},
      '{32'd0,  32'd0, 32'd0, 32'd0, 32'd2,  32'd2,  32'd0, 32'd0, 32'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              list_start = 1'b0;
   logic [63:0]       list_base = LBASE;
   logic [IDX_W-1:0]  last_idx = IDX_W'(3);
   logic [FIFO_W-1:0] fifo_size = FIFO_W'(4);
   logic              dir_to_mem = 1'b0;
   logic              xfer_valid = 1'b0;
   logic [31:0]       xfer_bytes = '0;
   logic              xfer_ready, xfer_done, chunk_go;
   logic [31:0]       xfer_moved;
   logic [FIFO_W-1:0] chunk_len;
   logic              mem_req, mem_we;
   logic [63:0]       mem_addr;
   logic [7:0]        mem_wdata;
   logic              mem_ack, mem_err;
   logic [7:0]        mem_rdata;
   logic              fifo_push, fifo_pop;
   logic [7:0]        fifo_push_data, fifo_pop_data;
   logic [IDX_W-1:0]  cur_idx;
   logic [31:0]       buf_off;
   logic [POS_W-1:0]  list_pos;
   logic [2:0]        sts;
   logic [2:0]        sts_clr = '0;
   logic              inject_err = 1'b0;

   bufdesc_dma #(.IDX_W(IDX_W), .FIFO_W(FIFO_W), .POS_W(POS_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .list_start(list_start), .list_base(list_base),
      .last_idx(last_idx), .fifo_size(fifo_size), .dir_to_mem(dir_to_mem),
      .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes), .xfer_ready(xfer_ready),
      .xfer_done(xfer_done), .xfer_moved(xfer_moved), .chunk_go(chunk_go),
      .chunk_len(chunk_len), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
      .fifo_push(fifo_push), .fifo_push_data(fifo_push_data), .fifo_pop(fifo_pop),
      .fifo_pop_data(fifo_pop_data), .cur_idx(cur_idx), .buf_off(buf_off),
      .list_pos(list_pos), .sts(sts), .sts_clr(sts_clr)
   );

   int checks = 0;
   int fails  = 0;

   function automatic logic [63:0] daddr(input int e);
      return DBASE + 64'(e) * 64'h100;
   endfunction

   function automatic logic [31:0] dlen(input int e);
      case (e)
         0: return 32'd10;
         1: return 32'd0;
         2: return 32'd6;
         default: return 32'd5;
      endcase
   endfunction

   function automatic logic [7:0] dbyte(input logic [63:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic logic [7:0] mbyte(input logic [63:0] a);
      int e, k;
      if (a >= LBASE && a < LBASE + 64) begin
         e = int'((a - LBASE) >> 4);
         k = int'((a - LBASE) & 64'hF);
         if (k < 8)       return 8'(daddr(e) >> (8 * k));
         else if (k < 12) return 8'(dlen(e) >> (8 * (k - 8)));
         else if (k == 12) return {7'b0, (e != 2)};
         else             return 8'h00;
      end
      return dbyte(a);
   endfunction

   // memory responder and FIFO source
   logic [7:0] pop_byte;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_err   <= 1'b0;
         mem_rdata <= '0;
         pop_byte  <= 8'h30;
      end else begin
         mem_ack   <= mem_req && !mem_ack;
         mem_err   <= inject_err && mem_req && !mem_ack && (mem_addr >= DBASE);
         mem_rdata <= mbyte(mem_addr);
         if (fifo_pop) pop_byte <= pop_byte + 8'd1;
      end
   end
   assign fifo_pop_data = pop_byte;

   // monitors
   int n_chunks = 0, n_push = 0, n_pop = 0, n_req = 0, wr_seen = 0, wr_good = 0;
   logic [7:0] push_x = '0;
   always @(negedge clk) begin
      if (chunk_go) n_chunks++;
      if (fifo_push) begin n_push++; push_x ^= fifo_push_data; end
      if (fifo_pop) n_pop++;
      if (mem_req) n_req++;
      if (mem_req && mem_we && mem_ack) begin
         if (mem_addr == DBASE + 64'(wr_seen) && mem_wdata == 8'h30 + 8'(wr_seen)) wr_good++;
         wr_seen++;
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic pulse_start();
      list_start = 1'b1;
      @(negedge clk);
      list_start = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_clr(input logic [2:0] m);
      sts_clr = m;
      @(negedge clk);
      sts_clr = '0;
      @(negedge clk);
   endtask

   task automatic run_xfer(input logic [31:0] n);
      while (!xfer_ready) @(negedge clk);
      xfer_bytes = n;
      xfer_valid = 1'b1;
      @(negedge clk);
      xfer_valid = 1'b0;
      while (!xfer_done) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int c0, p0, q0, r0;
      logic [7:0] x0, ex;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(xfer_ready == 1'b1, "R12", "ready after reset", xfer_ready, 1);
      chk(cur_idx == '0 && buf_off == '0, "R12", "index/offset after reset", cur_idx, 0);
      chk(list_pos == '0 && sts == '0, "R12", "position/status after reset", sts, 0);
      chk(mem_req == 1'b0, "R12", "no request in reset", mem_req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      pulse_start();

      // stimulus table: R1 R3 R4 R5 R6 R7 R8 R9 R11
      for (int v = 0; v < 8; v++) begin
         vec_t t;
         t = VECS[v];
         pulse_clr(3'b111);
         c0 = n_chunks; p0 = n_push; x0 = push_x;
         run_xfer(t.req);
         chk(xfer_moved == t.moved, "R4", $sformatf("v%0d moved", v), xfer_moved, t.moved);
         @(negedge clk);
         chk(n_chunks - c0 == int'(t.chunks), "R5", $sformatf("v%0d chunks", v), n_chunks - c0, t.chunks);
         chk(n_push - p0 == int'(t.moved), "R11", $sformatf("v%0d pushes", v), n_push - p0, t.moved);
         ex = '0;
         for (int k = 0; k < int'(t.moved); k++) ex ^= dbyte(daddr(int'(t.dent)) + 64'(t.soff) + 64'(k));
         chk((push_x ^ x0) == ex, "R1", $sformatf("v%0d data", v), push_x ^ x0, ex);
         chk(sts[0] == t.ioc[0], "R7", $sformatf("v%0d completion status", v), sts[0], t.ioc);
         chk(cur_idx == IDX_W'(t.idx), "R8", $sformatf("v%0d index", v), cur_idx, t.idx);
         chk(list_pos == POS_W'(t.pos), "R9", $sformatf("v%0d position", v), list_pos, t.pos);
         chk(buf_off == t.off, "R3", $sformatf("v%0d offset", v), buf_off, t.off);
         if (v == 2) chk(n_push == p0 && t.moved == 0, "R6", "zero-length entry moves nothing", n_push - p0, 0);
      end

      // R13 sticky status and masked clear
      pulse_start();
      pulse_clr(3'b111);
      run_xfer(32'd10);
      repeat (5) @(negedge clk);
      chk(sts[0] == 1'b1, "R13", "completion status sticky", sts[0], 1);
      pulse_clr(3'b010);
      chk(sts[0] == 1'b1, "R13", "other clear bit leaves status", sts[0], 1);
      pulse_clr(3'b001);
      chk(sts[0] == 1'b0, "R13", "matching clear drops status", sts[0], 0);

      // R11 capture direction: FIFO bytes written to memory
      dir_to_mem = 1'b1;
      pulse_start();
      p0 = n_push; q0 = n_pop;
      run_xfer(32'd4);
      @(negedge clk);
      chk(wr_good == 4 && wr_seen == 4, "R11", "memory writes with popped data", wr_good, 4);
      chk(n_pop - q0 == 4, "R11", "pops in capture direction", n_pop - q0, 4);
      chk(n_push == p0, "R11", "no pushes in capture direction", n_push - p0, 0);
      dir_to_mem = 1'b0;

      // R10 memory error on the data phase
      pulse_start();
      pulse_clr(3'b111);
      inject_err = 1'b1;
      p0 = n_push;
      run_xfer(32'd4);
      @(negedge clk);
      chk(xfer_moved == 0, "R10", "moved on error", xfer_moved, 0);
      chk(sts[1] == 1'b1, "R10", "error status", sts[1], 1);
      chk(n_push == p0 && buf_off == 0, "R10", "no byte after error", n_push - p0, 0);
      inject_err = 1'b0;
      run_xfer(32'd4);
      chk(xfer_moved == 4, "R10", "resume after error", xfer_moved, 4);

      // R2 zero base
      list_base = '0;
      pulse_start();
      pulse_clr(3'b111);
      r0 = n_req;
      run_xfer(32'd4);
      @(negedge clk);
      chk(xfer_moved == 0, "R2", "moved with zero base", xfer_moved, 0);
      chk(sts[2] == 1'b1, "R2", "zero-base status", sts[2], 1);
      chk(n_req == r0, "R2", "no memory request", n_req - r0, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule